// File: doc/BRIEF.md
# GRU Hidden-State Activation Pipeline

This block is the back end of a delta-driven gated recurrent unit layer. For every hidden unit it receives four persistent pre-activation sums: one for the reset gate, one for the update gate, and two for the candidate. One candidate sum comes from the input path and the other from the hidden path. It turns the two gate sums into gates with a piecewise-linear sigmoid. It scales the hidden-path candidate sum by the reset gate and adds the input-path sum. It squashes the result with a piecewise-linear tanh. Finally it blends the candidate with the unit's previous hidden value. The previous hidden values are held in a local register file that is cleared by reset and rewritten as each new value is produced.

One unit enters per cycle, with no stalls. The units of a timestep arrive in index order, and the final unit of the timestep is flagged. New hidden values leave as Q8.8 words packed four to a 64-bit beat. The beat holding the flagged unit carries the stream's last flag. The upstream matrix arithmetic keeps its sums in a wider fixed-point format. This block narrows those sums to Q8.8 before any nonlinearity is applied.

Top module: `gru_act_pipe`

## Requirements
- R1: After reset, `out_valid_o` is low until the first beat is produced, and every unit's stored previous hidden value is 0.
- R2: Each 32-bit sum s is read as signed with 16 fraction bits and narrowed to Q8.8 as floor((s + 128) / 256), clamped to [-32768, 32767].
- R3: The sigmoid of a Q8.8 value x, with a = |x|, is built as follows. f = 256 if a >= 1280; f = a/32 + 216 if a >= 608; f = a/8 + 160 if a >= 256; otherwise f = a/4 + 128. All divisions are floored. The result is f for x >= 0 and 256 - f for x < 0. The reset gate is the sigmoid of the narrowed reset sum, and the update gate is the sigmoid of the narrowed update sum.
- R4: tanh(x) = 2 * sigmoid(clamp16(2x)) - 256. It therefore saturates at +256 and -256 for large inputs.
- R5: The candidate is tanh(clamp16(cx + floor((r * ch + 128) / 256))). Here cx and ch are the narrowed input-path and hidden-path candidate sums, and r is the reset gate.
- R6: The new hidden value is h_prev + floor((u * (c - h_prev) + 128) / 256). This equals (1 - u)·h_prev + u·c in Q8.8. The unit index counts from 0 within each timestep, and the new value replaces h_prev for that index before the unit's next use.
- R7: Within a beat, the k-th unit of a group of four occupies bits [16k+15:16k]. The earliest unit is at bits [15:0].
- R8: The unit flagged last closes its beat even if the beat is only partly filled. Unfilled lanes read as zero. `out_last_o` is high only on that beat.
- R9: The block accepts a unit every cycle. The beat completed by a unit sampled at clock edge n is valid in the cycle after edge n+5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | A unit's four sums are present |
| in_last_i | input | 1 | This unit is the final one of the timestep |
| acc_reset_i | input | 32 | Reset-gate pre-activation sum |
| acc_update_i | input | 32 | Update-gate pre-activation sum |
| acc_cand_x_i | input | 32 | Input-path candidate sum |
| acc_cand_h_i | input | 32 | Hidden-path candidate sum |
| out_valid_o | output | 1 | Output beat valid |
| out_data_o | output | 64 | Four packed Q8.8 hidden values |
| out_last_o | output | 1 | Beat holds the timestep's final unit |

## Verification
A corrupted previous-hidden entry or a wrong unit index does not show up at once. It appears at the ports only when that unit is next blended, which is a full timestep later, and then only as a value error in one lane. For that reason the bench runs several timesteps back to back, including one-unit timesteps, so that a unit is reused while its previous result is still in the pipeline. Errors in the gate or tanh segments show up in the same beat as the affected unit, but only if the input lands in the faulty segment, so inputs are placed on both sides of every breakpoint. Packing and lane-counter faults show up within one beat as misplaced lanes, stale data in unfilled lanes, or a last flag on the wrong beat.

// File: rtl/gru_act_pkg.sv
package gru_act_pkg;
  localparam int Q_W    = 16;
  localparam int Q_FRAC = 8;
  localparam int W_W    = 48;

  typedef logic signed [Q_W-1:0] q_t;
  typedef logic signed [W_W-1:0] wide_t;

  localparam wide_t Q_ONE  = wide_t'(2 ** Q_FRAC);
  localparam wide_t Q_HALF = wide_t'(2 ** (Q_FRAC - 1));
  localparam wide_t Q_MAX  = wide_t'(2 ** (Q_W - 1) - 1);
  localparam wide_t Q_MIN  = -wide_t'(2 ** (Q_W - 1));

  function automatic q_t sat_q(wide_t v);
    if (v > Q_MAX) return q_t'(Q_MAX);
    if (v < Q_MIN) return q_t'(Q_MIN);
    return q_t'(v);
  endfunction

  // Q8.8 product, round half up
  function automatic wide_t mul_rnd(wide_t a, wide_t b);
    wide_t p;
    p = a * b;
    return (p + Q_HALF) >>> Q_FRAC;
  endfunction
endpackage

// File: rtl/gru_rescale.sv
module gru_rescale
  import gru_act_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int ACC_FRAC = 16
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output q_t                      q_o
);
  localparam int SH = ACC_FRAC - Q_FRAC;

  wide_t acc_w;
  assign acc_w = wide_t'(acc_i);

  generate
    if (SH > 0) begin : g_shift
      localparam wide_t RND = wide_t'(2 ** (SH - 1));
      assign q_o = sat_q((acc_w + RND) >>> SH);
    end else begin : g_pass
      assign q_o = sat_q(acc_w);
    end
  endgenerate
endmodule

// File: rtl/gru_pwl_act.sv
module gru_pwl_act
  import gru_act_pkg::*;
#(
  parameter bit IS_TANH = 1'b0
) (
  input  q_t x_i,
  output q_t y_o
);
  localparam wide_t BP_SAT  = 5 * Q_ONE;
  localparam wide_t BP_MID  = (19 * Q_ONE) / 8;
  localparam wide_t BP_LO   = Q_ONE;
  localparam wide_t OFS_HI  = (27 * Q_ONE) / 32;
  localparam wide_t OFS_MID = (5 * Q_ONE) / 8;
  localparam wide_t OFS_LO  = Q_ONE / 2;

  wide_t xs, mag, f, s;

  generate
    if (IS_TANH) begin : g_tanh_in
      assign xs = wide_t'(sat_q(wide_t'(x_i) * 2));
    end else begin : g_sig_in
      assign xs = wide_t'(x_i);
    end
  endgenerate

  always_comb begin
    mag = (xs < 0) ? -xs : xs;
    if (mag >= BP_SAT)      f = Q_ONE;
    else if (mag >= BP_MID) f = (mag >>> 5) + OFS_HI;
    else if (mag >= BP_LO)  f = (mag >>> 3) + OFS_MID;
    else                    f = (mag >>> 2) + OFS_LO;
    s = (xs < 0) ? (Q_ONE - f) : f;
  end

  generate
    if (IS_TANH) begin : g_tanh_out
      assign y_o = q_t'(2 * s - Q_ONE);
    end else begin : g_sig_out
      assign y_o = q_t'(s);
    end
  endgenerate
endmodule

// File: rtl/gru_hidden_rf.sv
module gru_hidden_rf
  import gru_act_pkg::*;
#(
  parameter int N_UNITS = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  q_t               wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output q_t               rdata_o
);
  q_t mem [N_UNITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_UNITS; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/gru_out_packer.sv
module gru_out_packer
  import gru_act_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               last_i,
  input  q_t                 data_i,
  output logic               valid_o,
  output logic               last_o,
  output logic [LANES*Q_W-1:0] data_o
);
  localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;

  q_t               lanes_q [LANES];
  q_t               lanes_n [LANES];
  logic [CNT_W-1:0] cnt_q;
  logic             close_beat;
  logic [LANES*Q_W-1:0] packed_n;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lanes_n[i] = (CNT_W'(i) == cnt_q) ? data_i : lanes_q[i];
      packed_n[i*Q_W +: Q_W] = lanes_n[i];
    end
    close_beat = last_i || (cnt_q == CNT_W'(LANES - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LANES; i++) lanes_q[i] <= '0;
      cnt_q   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (valid_i) begin
        if (close_beat) begin
          for (int i = 0; i < LANES; i++) lanes_q[i] <= '0;
          cnt_q   <= '0;
          valid_o <= 1'b1;
          last_o  <= last_i;
          data_o  <= packed_n;
        end else begin
          for (int i = 0; i < LANES; i++) lanes_q[i] <= lanes_n[i];
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gru_act_pipe.sv
module gru_act_pipe
  import gru_act_pkg::*;
#(
  parameter int N_UNITS  = 16,
  parameter int ACC_W    = 32,
  parameter int ACC_FRAC = 16,
  parameter int LANES    = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic                   in_last_i,
  input  logic [ACC_W-1:0]       acc_reset_i,
  input  logic [ACC_W-1:0]       acc_update_i,
  input  logic [ACC_W-1:0]       acc_cand_x_i,
  input  logic [ACC_W-1:0]       acc_cand_h_i,
  output logic                   out_valid_o,
  output logic [LANES*Q_W-1:0]   out_data_o,
  output logic                   out_last_o
);
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
  localparam int N_SUMS = 4;

  // sum order: reset, update, cand_x, cand_h
  logic [ACC_W-1:0] acc_in [N_SUMS];
  q_t               q_in   [N_SUMS];

  assign acc_in[0] = acc_reset_i;
  assign acc_in[1] = acc_update_i;
  assign acc_in[2] = acc_cand_x_i;
  assign acc_in[3] = acc_cand_h_i;

  generate
    for (genvar g = 0; g < N_SUMS; g++) begin : g_rescale
      gru_rescale #(.ACC_W(ACC_W), .ACC_FRAC(ACC_FRAC)) u_rescale (
        .acc_i (acc_in[g]),
        .q_o   (q_in[g])
      );
    end
  endgenerate

  // unit index within the timestep
  logic [IDX_W-1:0] idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (in_valid_i)
      idx_q <= (in_last_i || idx_q == IDX_W'(N_UNITS - 1)) ? '0 : idx_q + 1'b1;
  end

  // stage 0: narrowed sums
  logic v0, l0;
  logic [IDX_W-1:0] idx0;
  q_t r0, u0, cx0, ch0;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0 <= 1'b0; l0 <= 1'b0; idx0 <= '0;
      r0 <= '0; u0 <= '0; cx0 <= '0; ch0 <= '0;
    end else begin
      v0 <= in_valid_i; l0 <= in_last_i; idx0 <= idx_q;
      r0 <= q_in[0]; u0 <= q_in[1]; cx0 <= q_in[2]; ch0 <= q_in[3];
    end
  end

  // stage 1: gates
  q_t gr_c, gu_c;
  gru_pwl_act #(.IS_TANH(1'b0)) u_sig_r (.x_i(r0), .y_o(gr_c));
  gru_pwl_act #(.IS_TANH(1'b0)) u_sig_u (.x_i(u0), .y_o(gu_c));

  logic v1, l1;
  logic [IDX_W-1:0] idx1;
  q_t gr1, gu1, cx1, ch1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; l1 <= 1'b0; idx1 <= '0;
      gr1 <= '0; gu1 <= '0; cx1 <= '0; ch1 <= '0;
    end else begin
      v1 <= v0; l1 <= l0; idx1 <= idx0;
      gr1 <= gr_c; gu1 <= gu_c; cx1 <= cx0; ch1 <= ch0;
    end
  end

  // stage 2: reset gate scales only the hidden-path sum
  q_t cpre_c;
  assign cpre_c = sat_q(wide_t'(cx1) + mul_rnd(wide_t'(gr1), wide_t'(ch1)));

  logic v2, l2;
  logic [IDX_W-1:0] idx2;
  q_t cpre2, gu2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; l2 <= 1'b0; idx2 <= '0; cpre2 <= '0; gu2 <= '0;
    end else begin
      v2 <= v1; l2 <= l1; idx2 <= idx1; cpre2 <= cpre_c; gu2 <= gu1;
    end
  end

  // stage 3: candidate
  q_t cand_c;
  gru_pwl_act #(.IS_TANH(1'b1)) u_tanh_c (.x_i(cpre2), .y_o(cand_c));

  logic v3, l3;
  logic [IDX_W-1:0] idx3;
  q_t c3, gu3;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v3 <= 1'b0; l3 <= 1'b0; idx3 <= '0; c3 <= '0; gu3 <= '0;
    end else begin
      v3 <= v2; l3 <= l2; idx3 <= idx2; c3 <= cand_c; gu3 <= gu2;
    end
  end

  // stage 4: blend; h_prev read here so back-to-back reuse sees the latest write
  q_t h_prev3, h_next3;
  gru_hidden_rf #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_hidden_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (v3),
    .waddr_i (idx3),
    .wdata_i (h_next3),
    .raddr_i (idx3),
    .rdata_o (h_prev3)
  );

  assign h_next3 = q_t'(wide_t'(h_prev3) +
                        mul_rnd(wide_t'(gu3), wide_t'(c3) - wide_t'(h_prev3)));

  logic v4, l4;
  q_t h4;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v4 <= 1'b0; l4 <= 1'b0; h4 <= '0;
    end else begin
      v4 <= v3; l4 <= l3; h4 <= h_next3;
    end
  end

  gru_out_packer #(.LANES(LANES)) u_packer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v4),
    .last_i  (l4),
    .data_i  (h4),
    .valid_o (out_valid_o),
    .last_o  (out_last_o),
    .data_o  (out_data_o)
  );
endmodule

// File: rtl/gru_act_pipe_chk.sv
module gru_act_pipe_chk
  import gru_act_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_last_i,
  input logic out_valid_o,
  input logic out_last_o,
  input logic gate_v_i,
  input q_t   gate_r_i,
  input q_t   gate_u_i,
  input logic blend_v_i,
  input q_t   cand_i,
  input q_t   h_prev_i,
  input q_t   h_new_i
);
  localparam q_t ONE_Q = q_t'(Q_ONE);

  p_beat_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 6));

  p_last_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> ($past(in_valid_i, 6) && $past(in_last_i, 6)));

  p_gate_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_v_i |-> (gate_r_i >= 0 && gate_r_i <= ONE_Q && gate_u_i >= 0 && gate_u_i <= ONE_Q));

  p_cand_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blend_v_i |-> (cand_i >= -ONE_Q && cand_i <= ONE_Q));

  p_blend_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blend_v_i |-> ((cand_i >= h_prev_i) ? (h_new_i >= h_prev_i && h_new_i <= cand_i)
                                        : (h_new_i <= h_prev_i && h_new_i >= cand_i)));
endmodule

bind gru_act_pipe gru_act_pipe_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_last_i   (in_last_i),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .gate_v_i    (v1),
  .gate_r_i    (gr1),
  .gate_u_i    (gu1),
  .blend_v_i   (v3),
  .cand_i      (c3),
  .h_prev_i    (h_prev3),
  .h_new_i     (h_next3)
);

// File: tb/gru_act_pipe_bench.sv
module gru_act_pipe_bench;
  localparam int N_UNITS = 16;
  localparam int LAT     = 6;
  localparam int BIG     = 32'h7FFF_FFFF;
  localparam int SMALLEST = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [31:0] acc_r = '0, acc_u = '0, acc_cx = '0, acc_ch = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_last;

  always #5 clk = ~clk;

  gru_act_pipe u_gru_act_pipe (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .in_last_i    (in_last),
    .acc_reset_i  (acc_r),
    .acc_update_i (acc_u),
    .acc_cand_x_i (acc_cx),
    .acc_cand_h_i (acc_ch),
    .out_valid_o  (out_valid),
    .out_data_o   (out_data),
    .out_last_o   (out_last)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [63:0] data;
    logic        last;
    logic [31:0] due;
  } exp_t;

  exp_t  sb_q  [$];
  string tag_q [$];

  // independent reference model
  int hm [N_UNITS];
  int unit_i = 0;
  int lane_i = 0;
  logic [63:0] beat = '0;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int narrow(int s);   // R2
    return sat16((longint'(s) + 128) >>> 8);
  endfunction

  function automatic int rnd8(longint p);
    return int'((p + 128) >>> 8);
  endfunction

  function automatic int sigm(int x);     // R3
    int a, f;
    a = (x < 0) ? -x : x;
    if (a >= 1280)     f = 256;
    else if (a >= 608) f = a / 32 + 216;
    else if (a >= 256) f = a / 8 + 160;
    else               f = a / 4 + 128;
    return (x < 0) ? 256 - f : f;
  endfunction

  function automatic int tanh_m(int x);   // R4
    return 2 * sigm(sat16(2 * longint'(x))) - 256;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp_v, cyc);
    end
  endtask

  task automatic drive(int ar, int au, int ax, int ah, bit last, string tag);
    int r, u, cp, c, hp, hn;
    @(negedge clk);
    in_valid = 1'b1; in_last = last;
    acc_r = ar; acc_u = au; acc_cx = ax; acc_ch = ah;
    r  = sigm(narrow(ar));
    u  = sigm(narrow(au));
    cp = sat16(longint'(narrow(ax)) + rnd8(longint'(r) * narrow(ah)));   // R5
    c  = tanh_m(cp);
    hp = hm[unit_i];
    hn = hp + rnd8(longint'(u) * (c - hp));                              // R6
    hm[unit_i] = hn;
    beat[lane_i*16 +: 16] = hn[15:0];                                    // R7
    lane_i++;
    if (last || lane_i == 4) begin                                       // R8
      sb_q.push_back('{data: beat, last: last, due: cyc + LAT});         // R9
      tag_q.push_back(tag);
      beat = '0;
      lane_i = 0;
    end
    unit_i = (last || unit_i == N_UNITS - 1) ? 0 : unit_i + 1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  function automatic int rnd_acc();
    return $signed($urandom) >>> 12;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9 unexpected beat", out_data, 0);
        end else begin
          exp_t e;
          string t;
          e = sb_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e.data, t, out_data, e.data);
          chk(out_last == e.last, "R8 last flag", out_last, e.last);
          chk(cyc == int'(e.due), "R9 beat timing", cyc, e.due);
        end
      end else if (sb_q.size() != 0 && cyc >= int'(sb_q[0].due)) begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        chk(1'b0, "R9 missing beat", 0, e.data);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired, pending=%0d expected=0", sb_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_UNITS; i++) hm[i] = 0;
    repeat (3) @(negedge clk);
    // R1: idle outputs in and just after reset
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    end

    // R1: first timestep blends against a zeroed hidden state
    for (int i = 0; i < 4; i++)
      drive(rnd_acc(), 32'h0004_0000, rnd_acc(), rnd_acc(), i == 3, "R1 first blend");
    idle(2);

    // R2: rounding and clamping of the narrowed sums (u saturated so h = c)
    drive(0, BIG, 32'h0000_0180, 0, 1'b0, "R2 round up");
    drive(0, BIG, 32'h0000_017F, 0, 1'b0, "R2 round down");
    drive(0, BIG, -32'sh181,     0, 1'b0, "R2 negative");
    drive(0, BIG, -32'sh180,     0, 1'b0, "R2 negative half");
    drive(0, BIG, BIG,           0, 1'b0, "R2 clamp high");
    drive(0, BIG, SMALLEST,      0, 1'b1, "R2 clamp low");
    idle(1);

    // R3: update gate on both sides of each breakpoint, candidate pinned at +1
    begin
      int pts[12] = '{0, 255, 256, 607, 608, 1279, 1280, 2048, -256, -608, -1280, -2048};
      for (int i = 0; i < 12; i++)
        drive(0, pts[i] * 256, BIG, 0, i == 11, "R3 sigmoid");
    end
    idle(3);

    // R4: candidate around tanh breakpoints, update saturated
    begin
      int pts[12] = '{127, 128, 303, 304, 639, 640, -127, -128, -304, -640, 8000, -8000};
      for (int i = 0; i < 12; i++)
        drive(0, BIG, pts[i] * 256, 0, i == 11, "R4 tanh");
    end

    // R5: reset gate scales only the hidden-path sum
    drive(BIG,      BIG, 0,              32'h0001_0000, 1'b0, "R5 r one");
    drive(SMALLEST, BIG, 32'h0000_8000,  32'h0010_0000, 1'b0, "R5 r zero");
    drive(0,        BIG, 32'h0000_4000,  32'hFFFF_0000, 1'b0, "R5 r half");
    drive(32'h0001_0000, BIG, -32'sh8000, 32'h0002_0000, 1'b1, "R5 r mid");
    idle(1);

    // R7: lane order with distinct values
    drive(0, BIG, 32'h0000_0200, 0, 1'b0, "R7 lane order");
    drive(0, BIG, 32'h0000_0400, 0, 1'b0, "R7 lane order");
    drive(0, BIG, 32'h0000_0600, 0, 1'b0, "R7 lane order");
    drive(0, BIG, 32'h0000_0800, 0, 1'b1, "R7 lane order");

    // R8: six-unit timestep leaves a half-filled closing beat
    for (int i = 0; i < 6; i++)
      drive(rnd_acc(), rnd_acc(), rnd_acc(), rnd_acc(), i == 5, "R8 partial beat");

    // R6: single-unit timesteps back to back reuse unit 0 every cycle
    for (int i = 0; i < 5; i++)
      drive(rnd_acc(), rnd_acc(), rnd_acc(), rnd_acc(), 1'b1, "R6 back-to-back reuse");

    // R6/R9: full timesteps at full rate, random sums
    for (int s = 0; s < 6; s++)
      for (int i = 0; i < N_UNITS; i++)
        drive(rnd_acc(), rnd_acc(), rnd_acc(), rnd_acc(), i == N_UNITS - 1, "R6 blend");
    idle(1);

    // R6: gapped timesteps
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < N_UNITS; i++) begin
        drive(rnd_acc(), rnd_acc(), rnd_acc(), rnd_acc(), i == N_UNITS - 1, "R6 gapped");
        if (i % 5 == 2) idle(2);
      end
    end
    idle(1);

    for (int i = 0; i < 50 && sb_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    chk(sb_q.size() == 0, "R9 all beats produced", sb_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule